// File: doc/BRIEF.md
# Two-Read ADC Result Port

This block hands a 10-bit conversion result to a host over an 8-bit parallel bus. The host gets the full result in two read accesses. The first access returns the eight most significant bits. The second returns the two least significant bits, left-justified, with zero fill below them. An internal half pointer selects which part drives the bus. The pointer flips each time a read access ends. It is forced back to the high-byte position whenever a conversion is running. Because of this, a host that only ever issues one read per conversion sees the port as a plain 8-bit converter.

Chip-select and read strobes are active low and come from the host side. They pass through a synchronizer before edge detection, so the pointer steps a few cycles after the host releases the strobes. The bus enable is formed directly from the raw strobes and acts as the tri-state control.

A read that overlaps the conversion-busy flag returns meaningless data. The port raises a flag for any such read. The flag stays up until the next read access begins. A bound checker also watches for conversions that start too soon after the end of a read.

Top module: `adc_result_port`

## Requirements
- R1: `bus_oe_o` is 1 exactly while `cs_ni` and `rd_ni` are both 0. Whenever `bus_oe_o` is 0, `bus_o` reads all zeros.
- R2: The first read after reset or after a conversion drives result bits [9:2] on `bus_o[7:0]`.
- R3: The second read drives result bits [1:0] on `bus_o[7:6]` and zeros on `bus_o[5:0]`.
- R4: Further reads of the same stored result keep alternating between the high byte and the low bits.
- R5: While `busy_i` is 1, the half pointer is held at the high byte. A read sequence that was left on the low half therefore restarts at the high byte after the next conversion.
- R6: A read access during which `busy_i` is seen at 1 sets `rd_invalid_o`. The flag holds until the next access starts, and a read made with `busy_i` at 0 clears it.
- R7: `result_i` is captured when `result_vld_i` is 1. The captured value is held unchanged through any number of reads until the next load.
- R8: The pointer steps once per access, after the synchronized combined strobe deasserts. It does not step while `busy_i` is 1.
- R9: A conversion (rising `busy_i`) begins no earlier than `MIN_GAP_CYC` cycles after the synchronized end of the last read.
- R10: After reset, the stored result is zero, the pointer is at the high byte and `rd_invalid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| result_i | input | 10 | Conversion result from the converter |
| result_vld_i | input | 1 | Load strobe for `result_i` |
| busy_i | input | 1 | Conversion in progress |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| bus_o | output | 8 | Read data bus |
| bus_oe_o | output | 1 | Bus drive enable (tri-state control) |
| rd_invalid_o | output | 1 | Last read overlapped a conversion |

## Verification
The bench uses four read patterns.
- One read per conversion: this separates a pointer that is reset by BUSY from one that only toggles.
- Two reads: this checks the left-justified, zero-filled low half.
- Four reads of a single result: this shows that alternation continues and the stored value stays put.
- A read issued inside a BUSY window: this exercises the invalid flag, shows that the pointer is not advanced, and shows that a clean read clears the flag.

Result values are chosen with distinct upper and lower bits, so a swapped or misplaced field cannot match by accident. A chip-select-only access checks that the bus stays undriven.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  typedef enum logic {HALF_HI = 1'b0, HALF_LO = 1'b1} half_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= {WIDTH{RST_VAL}};
    else         stg_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= {WIDTH{RST_VAL}};
      else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/read_sequencer.sv
module read_sequencer
  import adc_port_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  busy_i,
  input  logic  access_i,
  output half_e half_o,
  output logic  access_end_o,
  output logic  invalid_o
);
  logic  access_q;
  logic  access_start;
  half_e half_q;
  logic  inval_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) access_q <= 1'b0;
    else         access_q <= access_i;
  end

  assign access_start = access_i & ~access_q;
  assign access_end_o = access_q & ~access_i;

  // conversion running pins the pointer to the high byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           half_q <= HALF_HI;
    else if (busy_i)       half_q <= HALF_HI;
    else if (access_end_o) half_q <= (half_q == HALF_HI) ? HALF_LO : HALF_HI;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           inval_q <= 1'b0;
    else if (access_start) inval_q <= busy_i;
    else if (access_i)     inval_q <= inval_q | busy_i;
  end

  assign half_o    = half_q;
  assign invalid_o = inval_q;
endmodule

// File: rtl/result_store.sv
module result_store
  import adc_port_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [RES_W-1:0] result_i,
  input  half_e            half_i,
  input  logic             oe_i,
  output logic [BUS_W-1:0] bus_o
);
  localparam int LO_W = RES_W - BUS_W;

  logic [RES_W-1:0] res_q;
  logic [BUS_W-1:0] sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (load_i) res_q <= result_i;
  end

  // low part left-justified, zero filled
  always_comb begin
    if (half_i == HALF_HI) sel = res_q[RES_W-1:LO_W];
    else                   sel = {res_q[LO_W-1:0], {(BUS_W-LO_W){1'b0}}};
  end

  assign bus_o = oe_i ? sel : '0;
endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
  import adc_port_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_GAP_CYC = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [RES_W-1:0] result_i,
  input  logic             result_vld_i,
  input  logic             busy_i,
  input  logic             cs_ni,
  input  logic             rd_ni,
  output logic [BUS_W-1:0] bus_o,
  output logic             bus_oe_o,
  output logic             rd_invalid_o
);
  logic [1:0] strb_s;
  logic       access_s;
  logic       access_end;
  half_e      half;

  assign bus_oe_o = ~cs_ni & ~rd_ni;

  strobe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, rd_ni}),
    .q_o   (strb_s)
  );

  assign access_s = ~strb_s[1] & ~strb_s[0];

  read_sequencer u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy_i),
    .access_i    (access_s),
    .half_o      (half),
    .access_end_o(access_end),
    .invalid_o   (rd_invalid_o)
  );

  result_store #(.RES_W(RES_W), .BUS_W(BUS_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (result_vld_i),
    .result_i(result_i),
    .half_i  (half),
    .oe_i    (bus_oe_o),
    .bus_o   (bus_o)
  );
endmodule

// File: rtl/adc_result_port_chk.sv
module adc_result_port_chk
  import adc_port_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int RES_W       = 10,
  parameter int MIN_GAP_CYC = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             bus_oe_o,
  input logic [BUS_W-1:0] bus_o,
  input logic             rd_invalid_o,
  input logic             access_s,
  input logic             access_end,
  input half_e            half
);
  localparam int LO_W  = RES_W - BUS_W;
  localparam int GAP_W = $clog2(MIN_GAP_CYC + 1);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           gap_q <= GAP_W'(MIN_GAP_CYC);
    else if (access_end)                   gap_q <= '0;
    else if (gap_q < GAP_W'(MIN_GAP_CYC))  gap_q <= gap_q + 1'b1;
  end

  assert_idle_bus_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> bus_o == '0);

  assert_lo_fill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o && half == HALF_LO) |-> bus_o[BUS_W-LO_W-1:0] == '0);

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_end && !busy_i) |=> half != $past(half));

  assert_busy_home_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> half == HALF_HI);

  assert_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_s && busy_i) |=> rd_invalid_o);

  assert_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> gap_q >= GAP_W'(MIN_GAP_CYC));
endmodule

bind adc_result_port adc_result_port_chk #(
  .BUS_W(BUS_W), .RES_W(RES_W), .MIN_GAP_CYC(MIN_GAP_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy_i),
  .bus_oe_o    (bus_oe_o),
  .bus_o       (bus_o),
  .rd_invalid_o(rd_invalid_o),
  .access_s    (access_s),
  .access_end  (access_end),
  .half        (half)
);

// File: tb/adc_result_port_tb.sv
module adc_result_port_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] result_i = '0;
  logic       result_vld_i = 1'b0;
  logic       busy_i = 1'b0;
  logic       cs_ni = 1'b1;
  logic       rd_ni = 1'b1;
  logic [7:0] bus_o;
  logic       bus_oe_o;
  logic       rd_invalid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  adc_result_port u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .result_i(result_i),
    .result_vld_i(result_vld_i), .busy_i(busy_i), .cs_ni(cs_ni),
    .rd_ni(rd_ni), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
    .rd_invalid_o(rd_invalid_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hi_of(input logic [9:0] v);
    return v[9:2];
  endfunction

  function automatic logic [7:0] lo_of(input logic [9:0] v);
    return {v[1:0], 6'b0};
  endfunction

  // read access; checks bus value and release behaviour
  task automatic do_read(input logic [7:0] exp, input string req);
    @(negedge clk_i); cs_ni = 1'b0; rd_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(bus_oe_o === 1'b1, "R1 oe during read", int'(bus_oe_o), 1);
    check(bus_o === exp, req, int'(bus_o), int'(exp));
    cs_ni = 1'b1; rd_ni = 1'b1;
    #1;
    check(bus_oe_o === 1'b0 && bus_o === 8'h00, "R1 released", int'(bus_o), 0);
    repeat (6) @(negedge clk_i);
  endtask

  // conversion respecting the minimum gap; loads value as busy falls
  task automatic convert(input logic [9:0] val);
    repeat (12) @(negedge clk_i);
    busy_i = 1'b1;
    repeat (8) @(negedge clk_i);
    busy_i = 1'b0; result_vld_i = 1'b1; result_i = val;
    @(negedge clk_i);
    result_vld_i = 1'b0; result_i = ~val;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic t_reset;
    check(bus_oe_o === 1'b0 && bus_o === 8'h00, "R10 bus idle", int'(bus_o), 0);
    check(rd_invalid_o === 1'b0, "R10 flag clear", int'(rd_invalid_o), 0);
    do_read(8'h00, "R10 stored zero hi");
    do_read(8'h00, "R10 stored zero lo");
  endtask

  task automatic t_cs_only;
    @(negedge clk_i); cs_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    check(bus_oe_o === 1'b0 && bus_o === 8'h00, "R1 cs only", int'(bus_oe_o), 0);
    cs_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_single;
    // pointer is on the low half after t_reset's two reads? no: two reads -> hi
    convert(10'h2C5);
    do_read(hi_of(10'h2C5), "R2 single read hi");
    convert(10'h13A);
    do_read(hi_of(10'h13A), "R5 restart at hi after conversion");
  endtask

  task automatic t_two;
    convert(10'h3A7);
    do_read(hi_of(10'h3A7), "R2 first of two");
    do_read(lo_of(10'h3A7), "R3 second of two");
  endtask

  task automatic t_four;
    convert(10'h16E);
    do_read(hi_of(10'h16E), "R4 read1 hi");
    do_read(lo_of(10'h16E), "R4 read2 lo");
    do_read(hi_of(10'h16E), "R4 read3 hi");
    do_read(lo_of(10'h16E), "R7 read4 held lo");
  endtask

  task automatic t_busy_read;
    repeat (12) @(negedge clk_i);
    busy_i = 1'b1;
    repeat (2) @(negedge clk_i);
    cs_ni = 1'b0; rd_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    cs_ni = 1'b1; rd_ni = 1'b1;
    repeat (8) @(negedge clk_i);
    busy_i = 1'b0; result_vld_i = 1'b1; result_i = 10'h0F1;
    @(negedge clk_i);
    result_vld_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check(rd_invalid_o === 1'b1, "R6 flag after busy read", int'(rd_invalid_o), 1);
    do_read(hi_of(10'h0F1), "R8 no step during busy");
    check(rd_invalid_o === 1'b0, "R6 cleared by clean read", int'(rd_invalid_o), 0);
    do_read(lo_of(10'h0F1), "R3 low after busy read");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_cs_only;
    t_single;
    t_two;
    t_four;
    t_busy_read;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R10 act=0x0 exp=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule